// File: doc/BRIEF.md
# Binomial Bitstream Smoothing Filter

This block turns the single-bit output of a sigma-delta comparator into a multi-bit smoothed sample at the full input rate. It does so with a chain of identical sections. Each section adds its input word to the same word held back by one accepted sample. There are no multipliers and no coefficient storage. After N sections, the stream has been convolved N times with the two-tap kernel {1,1}. The resulting kernel is row N of the binomial coefficients, which is a near-Gaussian low-pass shape. Each section widens the word by one bit.

The section count is the parameter `STAGES`. It must be even and at least 2, so the kernel always has an odd length and a single centre tap. A sample is accepted only while `in_valid` is high. While it is low, the whole filter holds its state.

A second output taps the {1,2,1} point of the chain and emits one 3-bit value for every two accepted input bits. This gives a cheap half-rate stream alongside the full-rate one.

Top module: `binomial_smoother`

## Requirements
- R1: A synchronous reset clears every delay register, the fill count and the decimation phase, and drives `out_valid`, `dec_valid`, `out_sample` and `dec_sample` to zero.
- R2: `out_valid` is high only in the cycle after an accepted input, and only once `STAGES` inputs were accepted before that one since reset. For `STAGES`=4, the first valid output follows the 5th accepted bit.
- R3: One clock after each accepted bit, `out_sample` equals the sum of C(STAGES,j) times the bit accepted j samples earlier, for j = 0..STAGES. For `STAGES`=4, a lone 1 yields 1,4,6,4,1 on successive accepted samples.
- R4: `out_sample` is `STAGES`+1 bits wide. It reaches full scale 2^`STAGES` for a stream of all ones and 0 for all zeros, and it never exceeds 2^`STAGES`.
- R5: A cycle with `in_valid` low changes no state. The outputs hold their values, and both valid flags are low in the next cycle.
- R6: Accepted inputs alternate between two phases, starting with phase 0 after reset. On a phase-1 input, with at least 2 inputs accepted before it, `dec_valid` rises for one cycle. `dec_sample` then carries newest + 2*previous + oldest of the last three accepted bits, with a maximum of 4.
- R7: `dec_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `in_bit` this cycle |
| in_bit | input | 1 | Comparator bitstream sample |
| out_valid | output | 1 | `out_sample` holds a full-window result |
| out_sample | output | STAGES+1 | Binomially smoothed sample |
| dec_valid | output | 1 | `dec_sample` updated (half rate) |
| dec_sample | output | 3 | {1,2,1} smoothed sample, decimated by 2 |

## Verification
A lone 1 in a field of zeros reads out the impulse response directly. This shows whether each coefficient is the binomial value and whether the taps sit in the right order. Steady runs of ones and zeros test the full-scale and zero endpoints, as well as the word width. An alternating 1010 stream should settle at exactly half scale. It exposes taps with wrong weights, because the even-position and odd-position coefficient sums must match. Streams with `in_valid` gaps, followed by the decimated path, separate "hold on idle" from "advance on idle" and test the phase of the half-rate output.

// File: rtl/binomial_smoother.sv
module binomial_smoother #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              out_valid,
  output logic [STAGES:0]   out_sample,
  output logic              dec_valid,
  output logic [2:0]        dec_sample
);

  localparam int W  = STAGES + 1;
  localparam int CW = $clog2(STAGES + 1);
  localparam logic [W-1:0]  FULL   = {1'b1, {STAGES{1'b0}}};
  localparam logic [CW-1:0] FILLED = CW'(STAGES);
  localparam logic [CW-1:0] DEC_MIN = CW'(2);

  logic [W-1:0]  tap [0:STAGES];
  logic [CW-1:0] fill;
  logic          phase;

  assign tap[0] = {{STAGES{1'b0}}, in_bit};

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [W-1:0] held;
      always_ff @(posedge clk) begin
        if (rst)           held <= '0;
        else if (in_valid) held <= tap[k];
      end
      assign tap[k+1] = tap[k] + held;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      fill       <= '0;
      phase      <= 1'b0;
      out_valid  <= 1'b0;
      out_sample <= '0;
      dec_valid  <= 1'b0;
      dec_sample <= '0;
    end else begin
      out_valid <= in_valid && (fill == FILLED);
      dec_valid <= in_valid && phase && (fill >= DEC_MIN);
      if (in_valid) begin
        out_sample <= tap[STAGES];
        phase      <= ~phase;
        if (fill != FILLED) fill <= fill + 1'b1;
        if (phase && (fill >= DEC_MIN)) dec_sample <= tap[2][2:0];
      end
    end
  end

  assert_valid_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    out_sample <= FULL);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_sample) && $stable(dec_sample) && !out_valid && !dec_valid));

  assert_dec_range_R6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_sample <= 3'd4));

  assert_dec_alternates_R7: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

endmodule

// File: tb/test_binomial_smoother.sv
module test_binomial_smoother;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_valid, dec_valid;
  logic [N:0] out_sample;
  logic [2:0] dec_sample;

  int checks = 0;
  int errors = 0;

  int hist [0:N];
  int seen, e_sample, e_dec;
  bit phase;

  binomial_smoother #(.STAGES(N)) i_binomial_smoother (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_sample(out_sample),
    .dec_valid(dec_valid), .dec_sample(dec_sample));

  always #5 clk = ~clk;

  function automatic int choose(input int n, input int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int j = 0; j <= N; j++) hist[j] = 0;
    seen = 0; phase = 0; e_sample = 0; e_dec = 0;
  endtask

  task automatic push(input bit v, input bit b, input string tag);
    bit e_ov, e_dv;
    @(negedge clk);
    in_valid = v; in_bit = b;
    e_ov = 0; e_dv = 0;
    if (v) begin
      for (int j = N; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = b;
      e_ov = (seen >= N);
      e_sample = 0;
      for (int j = 0; j <= N; j++) e_sample += choose(N, j) * hist[j];
      e_dv = phase && (seen >= 2);
      if (e_dv) e_dec = hist[0] + 2 * hist[1] + hist[2];
      phase = !phase;
      if (seen < N) seen++;
    end
    @(posedge clk); #1;
    chk(out_valid == e_ov, {tag, " out_valid"}, out_valid, e_ov);
    chk(out_sample == e_sample, {tag, " out_sample"}, out_sample, e_sample);
    chk(dec_valid == e_dv, {tag, " dec_valid"}, dec_valid, e_dv);
    chk(dec_sample == e_dec, {tag, " dec_sample"}, dec_sample, e_dec);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_bit = 0;
    repeat (2) @(posedge clk);
    #1;
    model_clear();
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(dec_valid == 0, "R1 dec_valid", dec_valid, 0);
    chk(out_sample == 0, "R1 out_sample", out_sample, 0);
    chk(dec_sample == 0, "R1 dec_sample", dec_sample, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_reset_clears();
    do_reset();
    for (int i = 0; i < 8; i++) push(1, 1, "R4 ones");
    do_reset();
    for (int i = 0; i < 6; i++) push(1, 0, "R1 zero history");
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < N + 3; i++) push(1, 1, "R2 fill");
    chk(out_valid == 1, "R2 valid after fill", out_valid, 1);
  endtask

  task automatic t_impulse();
    do_reset();
    for (int i = 0; i < N + 1; i++) push(1, 0, "R3 lead");
    push(1, 1, "R3 impulse");
    for (int i = 0; i < N + 2; i++) push(1, 0, "R3 tail");
  endtask

  task automatic t_full_scale();
    do_reset();
    for (int i = 0; i < N + 4; i++) push(1, 1, "R4 ones");
    chk(out_sample == (1 << N), "R4 full scale", out_sample, 1 << N);
    for (int i = 0; i < N + 2; i++) push(1, 0, "R4 zeros");
    chk(out_sample == 0, "R4 zero", out_sample, 0);
  endtask

  task automatic t_alternating();
    do_reset();
    for (int i = 0; i < 12; i++) push(1, i[0], "R3 alternating");
    chk(out_sample == (1 << (N - 1)), "R3 half scale", out_sample, 1 << (N - 1));
  endtask

  task automatic t_stall();
    do_reset();
    for (int i = 0; i < 20; i++) begin
      push(1, (i % 3) == 0, "R5 data");
      if (i % 4 == 1) begin
        push(0, 1, "R5 idle");
        push(0, 0, "R5 idle");
      end
    end
  endtask

  task automatic t_decimate();
    do_reset();
    for (int i = 0; i < 16; i++) push(1, (i % 5) < 2, "R6 decimate");
    for (int i = 0; i < 6; i++) push(1, 1, "R6 dec full");
    chk(dec_sample <= 4, "R7 dec max", dec_sample, 4);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    t_reset_clears();
    t_fill();
    t_impulse();
    t_full_scale();
    t_alternating();
    t_stall();
    t_decimate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule